// File: doc/BRIEF.md
# Halfword-to-Word Host Write Joiner

This block sits between a 16-bit parallel host bus and a register space that only accepts full 32-bit accesses. The host always reaches a 32-bit register through two halfword transfers. On a write, the halfword aimed at the lower address of a word is captured in a staging register. Only the following write to the upper halfword produces a single one-cycle commit on the internal side, carrying the word address and the joined 32-bit value. The staged halfword never reaches a register by itself, so a register keeps its old contents until the pair is complete.

Reads follow the same order. A read of the lower halfword fetches the whole internal word in that cycle and keeps its other half. A later read of the upper halfword returns the kept half rather than fetching again, so the two halves the host sees come from one coherent snapshot.

The host address is an 11-bit byte address. Bit 0 is always zero on a 16-bit bus and is not carried, so the port holds bits 10..1. Bit 1 picks the halfword. The halfword at the lower address (bit 1 = 0) maps to bits 31:16 of the word, and the halfword at the upper address maps to bits 15:0.

Top module: `hw_write_joiner`

## Requirements
- R1: After reset, `int_wr`, `seq_err` and `hw_rdata` are all zero.
- R2: A host write with address bit 1 = 0 causes no internal write; it only replaces the staged halfword and its word address.
- R3: A host write with address bit 1 = 1 raises `int_wr` for exactly the next clock cycle. In that cycle `int_waddr` equals the byte address of the write with bits 1:0 cleared.
- R4: The committed data is {staged halfword, upper-halfword data}. Writing 0x1234 at 0x400 and then 0x5678 at 0x402 stores 0x12345678 at word 0x400.
- R5: An upper-halfword write still commits when no lower half is staged for the same word. In the commit cycle, `seq_err` is 1 in that case and 0 when the staged word address matches.
- R6: A commit consumes the staged pairing, but the staged data itself remains. A second upper-halfword write without a new lower write reuses the same staged halfword and reports `seq_err` = 1.
- R7: A host read with address bit 1 = 0 (and no write) raises `int_rd` in the same cycle with `int_raddr` equal to the word address. In the next cycle `hw_rdata` equals `int_rdata[31:16]`.
- R8: A host read with address bit 1 = 1 does not raise `int_rd`. In the next cycle `hw_rdata` equals bits 15:0 of the word fetched by the most recent lower-halfword read, even if that word has since changed.
- R9: When `hw_wr` and `hw_rd` are high together, the write is performed and the read is ignored: `int_rd` stays low and `hw_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_wr | input | 1 | Host halfword write strobe, one cycle per transfer |
| hw_rd | input | 1 | Host halfword read strobe, one cycle per transfer |
| hw_addr | input | ADDR_W-1 (10) | Host byte address bits 10..1 |
| hw_wdata | input | HW_W (16) | Host write halfword |
| hw_rdata | output | HW_W (16) | Host read halfword, valid the cycle after `hw_rd` |
| int_wr | output | 1 | One-cycle internal word write strobe |
| int_waddr | output | ADDR_W (11) | Internal write byte address, bits 1:0 zero |
| int_wdata | output | 2*HW_W (32) | Internal write word |
| seq_err | output | 1 | Commit had no matching staged lower half |
| int_rd | output | 1 | Internal word read request (combinational) |
| int_raddr | output | ADDR_W (11) | Internal read byte address, bits 1:0 zero |
| int_rdata | input | 2*HW_W (32) | Internal read word, returned in the same cycle |

## Verification
The assertions check on every cycle that a commit follows exactly the upper-halfword writes, one cycle later, with the right word address and low half. They also check that internal reads happen only for lower-halfword reads with no write in the same cycle, and that the high read half appears one cycle after such a read. The pairing of staged data with a later upper write can only be shown by the bench's write orderings. So can the mismatch and reuse flags, and the coherence of an upper read against a word that changed after its lower read. The bench shows these through a behavioural register file and a reference model.

// File: rtl/hw_write_joiner.sv
module hw_write_joiner #(
  parameter int ADDR_W = 11,
  parameter int HW_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_wr,
  input  logic                hw_rd,
  input  logic [ADDR_W-1:1]   hw_addr,
  input  logic [HW_W-1:0]     hw_wdata,
  output logic [HW_W-1:0]     hw_rdata,
  output logic                int_wr,
  output logic [ADDR_W-1:0]   int_waddr,
  output logic [2*HW_W-1:0]   int_wdata,
  output logic                seq_err,
  output logic                int_rd,
  output logic [ADDR_W-1:0]   int_raddr,
  input  logic [2*HW_W-1:0]   int_rdata
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] cur_word;
  logic            upper_sel;
  logic            wr_lo, wr_hi, rd_ok;

  logic [HW_W-1:0] stage_q;
  logic [WA_W-1:0] stage_word_q;
  logic            stage_vld_q;
  logic [HW_W-1:0] lat_lo_q;

  assign cur_word  = hw_addr[ADDR_W-1:2];
  assign upper_sel = hw_addr[1];
  assign wr_lo     = hw_wr & ~upper_sel;
  assign wr_hi     = hw_wr &  upper_sel;
  assign rd_ok     = hw_rd & ~hw_wr;

  assign int_rd    = rd_ok & ~upper_sel;
  assign int_raddr = {cur_word, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q      <= '0;
      stage_word_q <= '0;
      stage_vld_q  <= 1'b0;
    end else if (wr_lo) begin
      stage_q      <= hw_wdata;
      stage_word_q <= cur_word;
      stage_vld_q  <= 1'b1;
    end else if (wr_hi) begin
      stage_vld_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_wr    <= 1'b0;
      int_waddr <= '0;
      int_wdata <= '0;
      seq_err   <= 1'b0;
    end else begin
      int_wr <= wr_hi;
      if (wr_hi) begin
        int_waddr <= {cur_word, 2'b00};
        int_wdata <= {stage_q, hw_wdata};
        seq_err   <= ~(stage_vld_q && (stage_word_q == cur_word));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_lo_q <= '0;
      hw_rdata <= '0;
    end else if (rd_ok) begin
      if (!upper_sel) begin
        lat_lo_q <= int_rdata[HW_W-1:0];
        hw_rdata <= int_rdata[2*HW_W-1:HW_W];
      end else begin
        hw_rdata <= lat_lo_q;
      end
    end
  end
endmodule

// File: rtl/hw_write_joiner_chk.sv
module hw_write_joiner_chk #(
  parameter int ADDR_W = 11,
  parameter int HW_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_wr,
  input logic              hw_rd,
  input logic [ADDR_W-1:1] hw_addr,
  input logic [HW_W-1:0]   hw_wdata,
  input logic [HW_W-1:0]   hw_rdata,
  input logic              int_wr,
  input logic [ADDR_W-1:0] int_waddr,
  input logic [2*HW_W-1:0] int_wdata,
  input logic              int_rd,
  input logic [2*HW_W-1:0] int_rdata
);
  // R2
  lo_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr && !hw_addr[1]) |=> !int_wr);

  // R3
  hi_write_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr && hw_addr[1]) |=> int_wr);

  // R3
  no_spurious_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_wr && hw_addr[1]) |=> !int_wr);

  // R3
  commit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr && hw_addr[1]) |=> (int_waddr == {$past(hw_addr[ADDR_W-1:2]), 2'b00}));

  // R4
  commit_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr && hw_addr[1]) |=> (int_wdata[HW_W-1:0] == $past(hw_wdata)));

  // R7
  rd_req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd |-> (hw_rd && !hw_addr[1]));

  // R7
  rd_high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd |=> (hw_rdata == $past(int_rdata[2*HW_W-1:HW_W])));

  // R9
  wr_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_wr |-> !int_rd);

  // R9
  rd_ignored_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr || !hw_rd) |=> $stable(hw_rdata));
endmodule

bind hw_write_joiner hw_write_joiner_chk #(.ADDR_W(ADDR_W), .HW_W(HW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_wr(hw_wr), .hw_rd(hw_rd), .hw_addr(hw_addr),
  .hw_wdata(hw_wdata), .hw_rdata(hw_rdata), .int_wr(int_wr),
  .int_waddr(int_waddr), .int_wdata(int_wdata), .int_rd(int_rd),
  .int_rdata(int_rdata)
);

// File: tb/sim_hw_write_joiner.sv
module sim_hw_write_joiner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_wr = 1'b0, hw_rd = 1'b0;
  logic [10:1] hw_addr = '0;
  logic [15:0] hw_wdata = '0;
  logic [15:0] hw_rdata;
  logic        int_wr, seq_err, int_rd;
  logic [10:0] int_waddr, int_raddr;
  logic [31:0] int_wdata;
  logic [31:0] int_rdata = '0;

  int tests = 0, fails = 0;
  logic [31:0] mem [512];

  logic [15:0] m_stage = '0, m_latch = '0, e_rdata = '0;
  logic [8:0]  m_sw = '0;
  bit          m_sv = 0, e_wr = 0, e_err = 0;
  logic [10:0] e_addr = '0;
  logic [31:0] e_wdata = '0;

  always #4 clk = ~clk;

  hw_write_joiner u0 (
    .clk(clk), .rst_n(rst_n), .hw_wr(hw_wr), .hw_rd(hw_rd), .hw_addr(hw_addr),
    .hw_wdata(hw_wdata), .hw_rdata(hw_rdata), .int_wr(int_wr),
    .int_waddr(int_waddr), .int_wdata(int_wdata), .seq_err(seq_err),
    .int_rd(int_rd), .int_raddr(int_raddr), .int_rdata(int_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input bit rd, input logic [10:0] a, input logic [15:0] d);
    bit exp_rd;
    @(negedge clk);
    hw_wr = wr; hw_rd = rd; hw_addr = a[10:1]; hw_wdata = d;
    int_rdata = mem[a[10:2]];
    #1;
    exp_rd = rd && !wr && !a[1];
    chk(wr && rd ? "R9" : "R7", "int_rd", {31'b0, int_rd}, {31'b0, exp_rd});
    if (exp_rd) chk("R7", "int_raddr", {21'b0, int_raddr}, {21'b0, a[10:2], 2'b00});
    @(posedge clk);
    if (wr && !a[1]) begin
      m_stage = d; m_sw = a[10:2]; m_sv = 1; e_wr = 0;
    end else if (wr) begin
      e_wr = 1; e_addr = {a[10:2], 2'b00}; e_wdata = {m_stage, d};
      e_err = !(m_sv && m_sw == a[10:2]); m_sv = 0;
    end else e_wr = 0;
    if (rd && !wr) begin
      if (!a[1]) begin m_latch = int_rdata[15:0]; e_rdata = int_rdata[31:16]; end
      else e_rdata = m_latch;
    end
    #1;
    chk(wr && !a[1] ? "R2" : "R3", "int_wr", {31'b0, int_wr}, {31'b0, e_wr});
    if (e_wr) begin
      chk("R3", "int_waddr", {21'b0, int_waddr}, {21'b0, e_addr});
      chk("R4", "int_wdata", int_wdata, e_wdata);
      chk("R5", "seq_err", {31'b0, seq_err}, {31'b0, e_err});
    end
    chk(wr && rd ? "R9" : (a[1] ? "R8" : "R7"), "hw_rdata", {16'b0, hw_rdata}, {16'b0, e_rdata});
    if (int_wr) mem[int_waddr[10:2]] = int_wdata;
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "int_wr", {31'b0, int_wr}, 0);
    chk("R1", "seq_err", {31'b0, seq_err}, 0);
    chk("R1", "hw_rdata", {16'b0, hw_rdata}, 0);
    rst_n = 1'b1;

    // R2 then R4: worked example
    cyc(1, 0, 11'h400, 16'h1234);
    chk("R2", "reg after first half", mem[9'h100], 32'h0);
    cyc(1, 0, 11'h402, 16'h5678);
    cyc(0, 0, 0, 0);
    chk("R4", "reg after pair", mem[9'h100], 32'h12345678);
    // R7, R8 readback
    cyc(0, 1, 11'h400, 0);
    chk("R7", "read high half", {16'b0, hw_rdata}, 32'h1234);
    cyc(0, 1, 11'h402, 0);
    chk("R8", "read low half", {16'b0, hw_rdata}, 32'h5678);

    // R8 coherence: word changes between the two reads
    cyc(0, 1, 11'h400, 0);
    cyc(1, 0, 11'h400, 16'hAAAA);
    cyc(1, 0, 11'h402, 16'hBBBB);
    cyc(0, 1, 11'h402, 0);
    chk("R8", "kept half after update", {16'b0, hw_rdata}, 32'h5678);

    // R5 mismatch, R6 reuse
    cyc(1, 0, 11'h010, 16'hC0DE);
    cyc(1, 0, 11'h026, 16'h0001);
    chk("R5", "mismatch flag", {31'b0, seq_err}, 1);
    cyc(1, 0, 11'h02A, 16'h0002);
    chk("R6", "reused stage", int_wdata, 32'hC0DE0002);
    cyc(1, 0, 11'h02C, 16'h7777);
    cyc(1, 0, 11'h02E, 16'h8888);
    chk("R5", "match flag", {31'b0, seq_err}, 0);

    // R9 write beats read
    cyc(0, 1, 11'h02C, 0);
    cyc(1, 1, 11'h400, 16'h9999);
    chk("R9", "rdata held", {16'b0, hw_rdata}, 32'h7777);
    cyc(1, 1, 11'h402, 16'h4444);
    cyc(0, 0, 0, 0);
    chk("R9", "write done", mem[9'h100], 32'h99994444);

    // pattern sweep: pairs, readbacks, idle gaps
    lf = 16'hACE1;
    for (int w = 0; w < 40; w++) begin
      logic [10:0] ba;
      ba = {w[8:0], 2'b00} ^ 11'h155;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(1, 0, ba, lf);
      if (w % 3 == 0) cyc(0, 0, 0, 0);
      cyc(1, 0, ba | 11'h002, ~lf);
      cyc(0, 1, ba, 0);
      cyc(0, 1, ba | 11'h002, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule